// File: doc/BRIEF.md
# Execution Interval Timer

This block is a free-running 16-bit up-counter placed on an 8-bit I/O bus so that software can measure how long a stretch of code takes. It runs from the fast CPU clock through a modulo-28 prescaler, so the count advances once for every 28 CPU clock cycles.

Software starts a measurement by writing any value to the base port. The write zeroes the count and also resets the prescaler phase. Software then runs the code under test and reads the two count bytes from the base port and the port just above it.

The read data path is combinational. Reading one byte does not latch the other, so a two-byte read that straddles a carry can return a torn value. The count wraps silently, which means any single measurement must stay below 65536 ticks.

Top module: `tick_timer`

## Requirements
- R1: While rst_n is low, the count and the prescaler are held at zero. A read of either count port during reset returns 0x00.
- R2: The count rises by exactly one on the 28th rising clock edge after a clear or after reset release, and then every 28 edges after that. Between those edges it holds its value.
- R3: A bus cycle with io_stb=1, io_wr=1 and io_addr=0xE6 sets the count and the prescaler phase to zero on that edge, whatever the value on io_wdata.
- R4: A bus cycle with io_stb=1, io_wr=0 and io_addr=0xE6 drives count bits 7:0 onto io_rdata in the same cycle.
- R5: A bus cycle with io_stb=1, io_wr=0 and io_addr=0xE7 drives count bits 15:8 onto io_rdata in the same cycle.
- R6: When the count is 0xFFFF, the next tick takes it to 0x0000 with no other effect.
- R7: A read of any port other than 0xE6 or 0xE7 returns 0x00. A write to any port other than 0xE6, including 0xE7, leaves the count unchanged.
- R8: While io_stb=0, io_rdata is 0x00.
- R9: Reading the low byte does not freeze the high byte. A later read of 0xE7 returns the live count at the time of that read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | CPU clock |
| rst_n | input | 1 | Active-low reset, asserted asynchronously and released synchronously |
| io_stb | input | 1 | I/O cycle strobe |
| io_wr | input | 1 | 1 = output (write) cycle, 0 = input (read) cycle |
| io_addr | input | 8 | I/O port address |
| io_wdata | input | 8 | Write data (ignored by the clear) |
| io_rdata | output | 8 | Read data, zero when no count port is selected |

## Verification
Read data is combinational, so a read result is due in the same cycle that the strobe is driven. The monitor samples it a quarter period after the falling edge on which the driver set up the bus. A clear takes effect on the next rising edge, and the first increment lands on the 28th rising edge after it. The bench keeps a count of rising edges since the last clear and derives each expected byte from that count at the moment the item is queued. It also places reads at edge 27 and edge 28 to bracket each tick. Wrap-around is checked on a second instance built with a divide-by-2 prescaler, which lets the full 16-bit range finish within the run.

// File: rtl/tick_timer_pkg.sv
package tick_timer_pkg;
  localparam int unsigned DEF_DIV  = 28;
  localparam int unsigned DEF_CW   = 16;
  localparam int unsigned BUS_AW   = 8;
  localparam int unsigned BUS_DW   = 8;
  localparam logic [7:0]  DEF_BASE = 8'hE6;

  // register width for a counter running 0 .. n-1
  function automatic int unsigned mod_width(input int unsigned n);
    return (n < 2) ? 1 : $clog2(n);
  endfunction
endpackage

// File: rtl/tick_prescaler.sv
module tick_prescaler #(
  parameter int unsigned DIV = tick_timer_pkg::DEF_DIV,
  parameter int unsigned PW  = tick_timer_pkg::mod_width(DIV)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  output logic          tick,
  output logic [PW-1:0] pre_q
);
  localparam logic [PW-1:0] LAST = PW'(DIV - 1);

  logic [PW-1:0] pre_d;

  always_comb begin
    tick = (pre_q == LAST);
    if (clr) begin
      pre_d = '0;
    end else if (tick) begin
      pre_d = '0;
    end else begin
      pre_d = pre_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_q <= '0;
    end else begin
      pre_q <= pre_d;
    end
  end
endmodule

// File: rtl/tick_counter.sv
module tick_counter #(
  parameter int unsigned CW = tick_timer_pkg::DEF_CW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          tick,
  output logic [CW-1:0] cnt_q
);
  logic [CW-1:0] cnt_d;

  always_comb begin
    if (clr) begin
      cnt_d = '0;
    end else if (tick) begin
      cnt_d = cnt_q + 1'b1;
    end else begin
      cnt_d = cnt_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_d;
    end
  end
endmodule

// File: rtl/tick_port_dec.sv
module tick_port_dec #(
  parameter int unsigned   AW   = tick_timer_pkg::BUS_AW,
  parameter int unsigned   DW   = tick_timer_pkg::BUS_DW,
  parameter int unsigned   CW   = tick_timer_pkg::DEF_CW,
  parameter logic [AW-1:0] BASE = AW'(tick_timer_pkg::DEF_BASE)
) (
  input  logic          io_stb,
  input  logic          io_wr,
  input  logic [AW-1:0] io_addr,
  input  logic [CW-1:0] cnt,
  output logic          clr,
  output logic [DW-1:0] rdata
);
  localparam int unsigned NLANE = (CW + DW - 1) / DW;
  localparam int unsigned PADW  = NLANE * DW;

  logic [PADW-1:0]           cnt_pad;
  logic [NLANE-1:0]          hit;
  logic [NLANE-1:0][DW-1:0]  lane;

  assign cnt_pad = PADW'(cnt);
  assign clr     = io_stb & io_wr & (io_addr == BASE);

  for (genvar i = 0; i < NLANE; i++) begin : g_lane
    localparam logic [AW-1:0] LANE_ADDR = AW'(BASE + i);
    assign hit[i]  = io_stb & ~io_wr & (io_addr == LANE_ADDR);
    assign lane[i] = hit[i] ? cnt_pad[i*DW +: DW] : '0;
  end

  always_comb begin
    rdata = '0;
    for (int i = 0; i < NLANE; i++) begin
      rdata = rdata | lane[i];
    end
  end
endmodule

// File: rtl/tick_timer.sv
module tick_timer #(
  parameter int unsigned   DIV  = tick_timer_pkg::DEF_DIV,
  parameter int unsigned   CW   = tick_timer_pkg::DEF_CW,
  parameter int unsigned   AW   = tick_timer_pkg::BUS_AW,
  parameter int unsigned   DW   = tick_timer_pkg::BUS_DW,
  parameter logic [AW-1:0] BASE = AW'(tick_timer_pkg::DEF_BASE)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          io_stb,
  input  logic          io_wr,
  input  logic [AW-1:0] io_addr,
  input  logic [DW-1:0] io_wdata,
  output logic [DW-1:0] io_rdata
);
  localparam int unsigned PW = tick_timer_pkg::mod_width(DIV);

  logic          clr;
  logic          tick;
  logic [PW-1:0] pre_q;
  logic [CW-1:0] cnt_q;

  tick_port_dec #(.AW(AW), .DW(DW), .CW(CW), .BASE(BASE)) u_dec (
    .io_stb (io_stb),
    .io_wr  (io_wr),
    .io_addr(io_addr),
    .cnt    (cnt_q),
    .clr    (clr),
    .rdata  (io_rdata)
  );

  tick_prescaler #(.DIV(DIV), .PW(PW)) u_pre (
    .clk  (clk),
    .rst_n(rst_n),
    .clr  (clr),
    .tick (tick),
    .pre_q(pre_q)
  );

  tick_counter #(.CW(CW)) u_cnt (
    .clk  (clk),
    .rst_n(rst_n),
    .clr  (clr),
    .tick (tick),
    .cnt_q(cnt_q)
  );
endmodule

// File: rtl/tick_timer_chk.sv
module tick_timer_chk #(
  parameter int unsigned   DIV  = 28,
  parameter int unsigned   CW   = 16,
  parameter int unsigned   AW   = 8,
  parameter int unsigned   DW   = 8,
  parameter logic [AW-1:0] BASE = 8'hE6,
  parameter int unsigned   PW   = 5
) (
  input logic          clk,
  input logic          rst_n,
  input logic          io_stb,
  input logic          io_wr,
  input logic [AW-1:0] io_addr,
  input logic [DW-1:0] io_wdata,
  input logic [DW-1:0] io_rdata,
  input logic [PW-1:0] pre_q,
  input logic [CW-1:0] cnt_q
);
  localparam int unsigned   NLANE = (CW + DW - 1) / DW;
  localparam int unsigned   PADW  = NLANE * DW;
  localparam logic [PW-1:0] LAST  = PW'(DIV - 1);

  logic            wr_lo;
  logic [PADW-1:0] cnt_pad;
  logic [AW-1:0]   rel_addr;

  assign wr_lo    = io_stb && io_wr && (io_addr == BASE);
  assign cnt_pad  = PADW'(cnt_q);
  assign rel_addr = AW'(io_addr - BASE);

  always @(negedge clk) begin
    if (!rst_n) begin
      p_reset_r1: assert (cnt_q == '0 && pre_q == '0);
    end
  end

  p_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
    wr_lo |=> (cnt_q == '0 && pre_q == '0));

  p_clear_anydata_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_lo && io_wdata != '0) |=> cnt_q == '0);

  p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_lo && pre_q != LAST) |=> $stable(cnt_q));

  p_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_lo && pre_q == LAST) |=> cnt_q == CW'($past(cnt_q) + 1'b1));

  p_wrap_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_lo && pre_q == LAST && cnt_q == '1) |=> cnt_q == '0);

  p_lo_read_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (io_stb && !io_wr && rel_addr == '0) |-> io_rdata == cnt_pad[DW-1:0]);

  p_hi_read_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (io_stb && !io_wr && rel_addr == AW'(1) && NLANE > 1)
      |-> io_rdata == cnt_pad[(PADW > DW ? DW : 0) +: DW]);

  p_other_port_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (io_stb && !io_wr && rel_addr >= AW'(NLANE)) |-> io_rdata == '0);

  p_idle_bus_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !io_stb |-> io_rdata == '0);
endmodule

bind tick_timer tick_timer_chk #(
  .DIV(DIV), .CW(CW), .AW(AW), .DW(DW), .BASE(BASE), .PW(PW)
) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .io_stb  (io_stb),
  .io_wr   (io_wr),
  .io_addr (io_addr),
  .io_wdata(io_wdata),
  .io_rdata(io_rdata),
  .pre_q   (pre_q),
  .cnt_q   (cnt_q)
);

// File: tb/sim_tick_timer.sv
module sim_tick_timer;
  localparam int CLK_PERIOD = 10;
  localparam int DIV        = 28;
  localparam int FAST_DIV   = 2;
  localparam int WATCHDOG   = 200000;

  logic       clk;
  logic       rst_n;
  logic       stb0, wr0;
  logic [7:0] addr0, wdata0, rdata0;
  logic       stb1;
  logic [7:0] addr1, rdata1;
  logic       wr1;
  logic [7:0] wdata1;

  typedef struct {
    int         dut;
    logic [7:0] exp;
    string      tag;
  } item_t;

  item_t  sbq[$];
  int     checks = 0;
  int     errors = 0;
  longint since0, since1;
  bit     done = 0;

  tick_timer u0 (
    .clk(clk), .rst_n(rst_n), .io_stb(stb0), .io_wr(wr0),
    .io_addr(addr0), .io_wdata(wdata0), .io_rdata(rdata0)
  );

  tick_timer #(.DIV(FAST_DIV)) u1 (
    .clk(clk), .rst_n(rst_n), .io_stb(stb1), .io_wr(wr1),
    .io_addr(addr1), .io_wdata(wdata1), .io_rdata(rdata1)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  // reference: rising edges since the last clear (or reset)
  always @(posedge clk) begin
    if (!rst_n) begin
      since0 <= 0;
      since1 <= 0;
    end else begin
      if (stb0 && wr0 && addr0 == 8'hE6) since0 <= 0;
      else                                since0 <= since0 + 1;
      since1 <= since1 + 1;
    end
  end

  function automatic logic [7:0] exp_byte(input longint s, input int div,
                                          input logic [7:0] port);
    logic [15:0] c;
    c = 16'((s / div) % 65536);
    case (port)
      8'hE6:   return c[7:0];
      8'hE7:   return c[15:8];
      default: return 8'h00;
    endcase
  endfunction

  // driver: read at the falling edge where the reference count equals 'at'
  task automatic rd(input int dut, input logic [7:0] port, input longint at,
                    input string tag);
    item_t it;
    @(negedge clk);
    stb0 = 1'b0; stb1 = 1'b0;
    if (dut == 0) begin
      while (at >= 0 && since0 != at) @(negedge clk);
      stb0 = 1'b1; wr0 = 1'b0; addr0 = port;
      it.exp = exp_byte(since0, DIV, port);
    end else begin
      while (at >= 0 && since1 != at) @(negedge clk);
      stb1 = 1'b1; addr1 = port;
      it.exp = exp_byte(since1, FAST_DIV, port);
    end
    it.dut = dut;
    it.tag = tag;
    sbq.push_back(it);
  endtask

  task automatic wr(input logic [7:0] port, input logic [7:0] data);
    @(negedge clk);
    stb0 = 1'b1; wr0 = 1'b1; addr0 = port; wdata0 = data; stb1 = 1'b0;
  endtask

  task automatic idle_chk(input string tag);
    item_t it;
    @(negedge clk);
    stb0 = 1'b0; wr0 = 1'b0; addr0 = 8'hE6; stb1 = 1'b0;
    it.dut = 0; it.exp = 8'h00; it.tag = tag;
    sbq.push_back(it);
  endtask

  // monitor
  initial begin
    item_t      it;
    logic [7:0] act;
    forever begin
      @(negedge clk);
      #(CLK_PERIOD/4);
      if (sbq.size() > 0) begin
        it  = sbq.pop_front();
        act = (it.dut == 0) ? rdata0 : rdata1;
        checks++;
        if (act !== it.exp) begin
          errors++;
          $display("FAIL %s: got %02h expected %02h", it.tag, act, it.exp);
        end
      end
    end
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    stb0 = 1'b0; wr0 = 1'b0; addr0 = 8'h00; wdata0 = 8'h00;
    stb1 = 1'b0; wr1 = 1'b0; addr1 = 8'h00; wdata1 = 8'h00;
    repeat (3) @(negedge clk);
    // R1 reset state
    rd(0, 8'hE6, -1, "R1 low byte in reset");
    rd(0, 8'hE7, -1, "R1 high byte in reset");
    idle_chk("R8 idle bus in reset");
    @(negedge clk);
    rst_n = 1'b1;
    // R2 first tick after reset release
    rd(0, 8'hE6, 27, "R2 edge 27 after reset");
    rd(0, 8'hE6, 28, "R2 edge 28 after reset");
    // R7 writes elsewhere have no effect
    wr(8'hE7, 8'hFF);
    wr(8'hE5, 8'h55);
    rd(0, 8'hE6, 200, "R7 count after stray writes");
    // R3 clear with nonzero data, R2 tick spacing
    wr(8'hE6, 8'hA5);
    rd(0, 8'hE6, 0,  "R3 cleared by write of A5");
    rd(0, 8'hE6, 27, "R2 edge 27 after clear");
    rd(0, 8'hE6, 28, "R2 edge 28 after clear");
    rd(0, 8'hE6, 55, "R2 edge 55 after clear");
    rd(0, 8'hE6, 56, "R2 edge 56 after clear");
    // R7 other ports read zero
    rd(0, 8'hE5, -1, "R7 read port E5");
    rd(0, 8'hE8, -1, "R7 read port E8");
    rd(0, 8'h66, -1, "R7 read port 66");
    idle_chk("R8 idle bus running");
    // R3 clear with zero data, R4/R5/R9
    wr(8'hE6, 8'h00);
    rd(0, 8'hE6, 255*28,     "R4 low byte at FF");
    rd(0, 8'hE7, 256*28,     "R9 live high byte after carry");
    rd(0, 8'hE6, 256*28 + 1, "R4 low byte after carry");
    rd(0, 8'hE7, 291*28,     "R5 high byte at 0123");
    rd(0, 8'hE6, 291*28 + 1, "R4 low byte at 0123");
    // R3 back-to-back clears
    wr(8'hE6, 8'h3C);
    wr(8'hE6, 8'hC3);
    rd(0, 8'hE7, 0, "R3 high byte after double clear");
    rd(0, 8'hE6, 1, "R3 low byte after double clear");
    // R6 wrap on the fast instance
    rd(1, 8'hE6, 131070, "R6 low byte at FFFF");
    rd(1, 8'hE7, 131071, "R6 high byte at FFFF");
    rd(1, 8'hE6, 131072, "R6 low byte after wrap");
    rd(1, 8'hE7, 131073, "R6 high byte after wrap");
    @(negedge clk);
    stb0 = 1'b0; stb1 = 1'b0;
    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule